// File: doc/BRIEF.md
# Floating-Point Coprocessor Bus Sequencer

This block is the bus-facing controller of a floating-point slave coprocessor that sits beside a host CPU on a shared 16-bit data bus. The host announces each coprocessor instruction with an identification byte. It then writes an operation word and the operand words it has fetched. Every write or read is a single strobe, and a two-bit phase code from the host marks which protocol step the strobe belongs to. The block decodes the operation word to learn how many operands follow and how wide they are. It collects them and hands them to a fixed-latency placeholder execution unit. When the result is ready it pulses the strobe line back to the host.

After that completion pulse the host reads a status word. The status word carries a trap code for the two undefined opcode forms and the Z/N condition bits of a compare. The host then reads the result words one per strobe, low word first. A matching identification byte written at any moment abandons whatever is in progress and restarts the sequence. This lets the host retry an instruction that was aborted partway. Real IEEE arithmetic is out of scope: the execution unit computes simple bitwise stand-ins so that data paths can be traced.

Top module: `fps_seq`

## Requirements
- R1: While reset is held and after it is released, the block is idle: done_stb_n is 1, done_stb_oe is 0 and bus_dout_en is 0 until an instruction completes.
- R2: A write strobe with phase 2'b11 whose low byte equals ID_CODE (default 8'hA6) starts an instruction, and the next phase 2'b01 write is taken as the operation word. An identification byte with any other value leaves the block idle, and the writes that follow it are ignored.
- R3: The operation word selects the operation in bits [2:0]: 0 move, 1 xor, 2 compare, 3 negate, 4 absolute, 5 and. Bit 3 selects operand width: 0 means 2 bus words, 1 means 4 bus words. Operations 1, 2 and 5 take two operands and the others take one.
- R4: Operand words are accepted on write strobes with phase 2'b01, low word first, first operand complete before the second.
- R5: A strobe whose phase or direction does not match the current step (read strobes while collecting operands, writes with phase 2'b10 or 2'b00) changes neither the collected data nor the step.
- R6: The completion pulse drives done_stb_n low for exactly one clock. That clock begins EXEC_LAT (default 4) clock edges after the edge that accepted the last operand word.
- R7: Operation codes 6 and 7 are illegal: no operands are taken, the completion pulse occupies the clock that begins at the edge that accepted the operation word, the status trap field is 3'b100, and no result words follow.
- R8: After the completion pulse the block waits for a read strobe with phase 2'b10 and drives the status word: bits [2:0] trap code, bit 4 Z, bit 5 N, all other bits 0. bus_dout_en is 1 while the status or result words are offered.
- R9: A compare sets Z to 1 when both operands are equal. It sets N to 1 when the first is below the second as a two's-complement number of the operand width. It returns no result words.
- R10: Result words follow the status read, one per read strobe with phase 2'b01, low word first. Move copies the operand, xor and and combine the operands bitwise, negate inverts the operand's top bit and absolute clears it. After the last result word the block is idle.
- R11: A matching identification byte in any step, execution included, cancels the current instruction without a completion pulse, discards collected operands and waits for a new operation word.
- R12: Outside the completion pulse the strobe line is released: done_stb_oe is 0 and done_stb_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_stb | input | 1 | Host strobe, one clock per transfer |
| bus_rd | input | 1 | Transfer direction: 1 host reads, 0 host writes |
| bus_phase | input | 2 | Host phase code qualifying the strobe |
| bus_din | input | 16 | Data written by the host |
| bus_dout | output | 16 | Status or result word offered to the host |
| bus_dout_en | output | 1 | bus_dout is being driven |
| done_stb_n | output | 1 | Completion strobe value, low during the pulse |
| done_stb_oe | output | 1 | Drive enable for the completion strobe |

## Verification
A wrong step in the sequencer shows up at the ports within a clock or two. A lost or extra operand word moves the completion pulse away from its expected clock. A wrongly latched operation shows up as a bad status word or as result words that are missing or surplus. A failed restart shows up as a pulse that should never come. The bench runs its own reference of the protocol and compares the strobe, enable and data outputs on every clock, so a divergence is caught in the cycle it first reaches a port. Directed cases add exact pulse timing, hand-computed results for every operation and both widths, ignored strobes, foreign identification bytes and aborts during operand collection and during execution.

// File: rtl/fps_pkg.sv
package fps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPW,
      ST_OPND,
      ST_EXEC,
      ST_DONE,
      ST_STAT,
      ST_RES
   } seq_st_t;

   localparam logic [1:0] PH_NONE = 2'b00;
   localparam logic [1:0] PH_XFER = 2'b01;
   localparam logic [1:0] PH_STAT = 2'b10;
   localparam logic [1:0] PH_ID   = 2'b11;

   typedef enum logic [2:0] {
      OP_MOVE = 3'd0,
      OP_XOR  = 3'd1,
      OP_CMP  = 3'd2,
      OP_NEG  = 3'd3,
      OP_ABS  = 3'd4,
      OP_AND  = 3'd5,
      OP_BAD6 = 3'd6,
      OP_BAD7 = 3'd7
   } fop_t;

   localparam logic [2:0] TRAP_NONE = 3'b000;
   localparam logic [2:0] TRAP_ILL  = 3'b100;
   localparam int STAT_Z_BIT = 4;
   localparam int STAT_N_BIT = 5;

   typedef struct packed {
      fop_t op;
      logic dbl;
      logic two_src;
      logic illegal;
      logic makes_res;
   } fdec_t;

endpackage

// File: rtl/fps_decode.sv
module fps_decode
   import fps_pkg::*;
#(
   parameter int OPW = 16
) (
   input  logic [OPW-1:0] opw,
   output fdec_t          dec
);

   fop_t op_f;

   always_comb begin
      op_f          = fop_t'(opw[2:0]);
      dec.op        = op_f;
      dec.dbl       = opw[3];
      dec.illegal   = (op_f == OP_BAD6) || (op_f == OP_BAD7);
      dec.two_src   = (op_f == OP_XOR) || (op_f == OP_CMP) || (op_f == OP_AND);
      dec.makes_res = !dec.illegal && (op_f != OP_CMP);
   end

endmodule

// File: rtl/fps_opstore.sv
module fps_opstore #(
   parameter int DW  = 16,
   parameter int SWW = 2,
   parameter int DWW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr,
   input  logic                 dbl,
   input  logic [DW-1:0]        din,
   output logic [DWW*DW-1:0]    a_q,
   output logic [DWW*DW-1:0]    b_q,
   output logic [$clog2(2*DWW+1)-1:0] cnt
);

   localparam int IW = $clog2(2*DWW+1);

   logic [IW-1:0] wpo;

   assign wpo = dbl ? IW'(DWW) : IW'(SWW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (wr)
         cnt <= cnt + IW'(1);
   end

   for (genvar g = 0; g < DWW; g++) begin : g_slot
      logic [DW-1:0] a_r, b_r;
      logic          hit_a, hit_b;

      assign hit_a = wr && (cnt == IW'(g));
      assign hit_b = wr && (cnt == (wpo + IW'(g)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_r <= '0;
            b_r <= '0;
         end else begin
            if (hit_a) a_r <= din;
            if (hit_b) b_r <= din;
         end
      end

      assign a_q[g*DW +: DW] = a_r;
      assign b_q[g*DW +: DW] = b_r;
   end

endmodule

// File: rtl/fps_exec.sv
module fps_exec
   import fps_pkg::*;
#(
   parameter int DW  = 16,
   parameter int SWW = 2,
   parameter int DWW = 4,
   parameter int LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  fop_t              op,
   input  logic              dbl,
   input  logic [DWW*DW-1:0] a,
   input  logic [DWW*DW-1:0] b,
   output logic              fin,
   output logic [DWW*DW-1:0] res,
   output logic              z,
   output logic              n
);

   localparam int TW = DWW*DW;
   localparam int SB = SWW*DW;
   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

   logic          running;
   logic [CW-1:0] cnt;
   logic [TW-1:0] res_d;
   logic signed [TW-1:0] as_v, bs_v;

   for (genvar g = 0; g < DWW; g++) begin : g_lane
      logic [DW-1:0] aw, bw, rw;
      logic          top;
      always_comb begin
         aw  = a[g*DW +: DW];
         bw  = b[g*DW +: DW];
         top = dbl ? (g == DWW-1) : (g == SWW-1);
         case (op)
            OP_XOR:  rw = aw ^ bw;
            OP_AND:  rw = aw & bw;
            OP_NEG:  rw = top ? {~aw[DW-1], aw[DW-2:0]} : aw;
            OP_ABS:  rw = top ? {1'b0, aw[DW-2:0]} : aw;
            default: rw = aw;
         endcase
      end
      assign res_d[g*DW +: DW] = rw;
   end

   if (DWW > SWW) begin : g_ext
      assign as_v = dbl ? a : {{(TW-SB){a[SB-1]}}, a[SB-1:0]};
      assign bs_v = dbl ? b : {{(TW-SB){b[SB-1]}}, b[SB-1:0]};
   end else begin : g_flat
      assign as_v = a;
      assign bs_v = b;
   end

   assign fin = running && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
         res     <= '0;
         z       <= 1'b0;
         n       <= 1'b0;
      end else if (abort) begin
         running <= 1'b0;
      end else if (start) begin
         running <= 1'b1;
         cnt     <= CW'(LAT-1);
      end else if (running) begin
         if (cnt == '0) begin
            running <= 1'b0;
            res     <= res_d;
            z       <= (as_v == bs_v);
            n       <= (as_v < bs_v);
         end else begin
            cnt <= cnt - CW'(1);
         end
      end
   end

endmodule

// File: rtl/fps_seq.sv
module fps_seq
   import fps_pkg::*;
#(
   parameter int             DW        = 16,
   parameter int             IDW       = 8,
   parameter logic [IDW-1:0] ID_CODE   = 8'hA6,
   parameter int             SW_WORDS  = 2,
   parameter int             DW_WORDS  = 4,
   parameter int             EXEC_LAT  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_stb,
   input  logic          bus_rd,
   input  logic [1:0]    bus_phase,
   input  logic [DW-1:0] bus_din,
   output logic [DW-1:0] bus_dout,
   output logic          bus_dout_en,
   output logic          done_stb_n,
   output logic          done_stb_oe
);

   localparam int TW = DW_WORDS*DW;
   localparam int IW = $clog2(2*DW_WORDS+1);

   if (SW_WORDS < 1 || DW_WORDS < SW_WORDS) begin : g_bad_words
      $error("fps_seq: word counts out of range");
   end
   if (EXEC_LAT < 1) begin : g_bad_lat
      $error("fps_seq: EXEC_LAT must be at least 1");
   end
   if (DW < 8 || IDW > DW) begin : g_bad_width
      $error("fps_seq: bus width too small");
   end

   seq_st_t       state;
   fdec_t         dec_now;
   fop_t          op_q;
   logic          dbl_q, ill_q, mkres_q;
   logic [IW-1:0] need_q, ridx, wpo_q, wpo_now, cnt;
   logic [TW-1:0] a_all, b_all, res_all;
   logic          ex_fin, ex_z, ex_n;
   logic          wr_stb, rd_stb, id_hit, id_ours;
   logic          xfer_wr, xfer_rd, stat_rd, opw_take, opnd_take, last_w;
   logic [DW-1:0] stat_w;

   assign wr_stb  = bus_stb && !bus_rd;
   assign rd_stb  = bus_stb && bus_rd;
   assign id_hit  = wr_stb && (bus_phase == PH_ID);
   assign id_ours = id_hit && (bus_din[IDW-1:0] == ID_CODE);
   assign xfer_wr = wr_stb && (bus_phase == PH_XFER);
   assign xfer_rd = rd_stb && (bus_phase == PH_XFER);
   assign stat_rd = rd_stb && (bus_phase == PH_STAT);

   assign opw_take  = (state == ST_OPW)  && xfer_wr;
   assign opnd_take = (state == ST_OPND) && xfer_wr;
   assign last_w    = opnd_take && (cnt == need_q - IW'(1));

   fps_decode #(.OPW(DW)) u_dec (
      .opw (bus_din),
      .dec (dec_now)
   );

   assign wpo_now = dec_now.dbl ? IW'(DW_WORDS) : IW'(SW_WORDS);
   assign wpo_q   = dbl_q ? IW'(DW_WORDS) : IW'(SW_WORDS);

   fps_opstore #(.DW(DW), .SWW(SW_WORDS), .DWW(DW_WORDS)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (id_hit || opw_take),
      .wr    (opnd_take),
      .dbl   (dbl_q),
      .din   (bus_din),
      .a_q   (a_all),
      .b_q   (b_all),
      .cnt   (cnt)
   );

   fps_exec #(.DW(DW), .SWW(SW_WORDS), .DWW(DW_WORDS), .LAT(EXEC_LAT)) u_exec (
      .clk   (clk),
      .rst_n (rst_n),
      .abort (id_hit),
      .start (last_w),
      .op    (op_q),
      .dbl   (dbl_q),
      .a     (a_all),
      .b     (b_all),
      .fin   (ex_fin),
      .res   (res_all),
      .z     (ex_z),
      .n     (ex_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= OP_MOVE;
         dbl_q   <= 1'b0;
         ill_q   <= 1'b0;
         mkres_q <= 1'b0;
         need_q  <= '0;
         ridx    <= '0;
      end else if (id_hit) begin
         state <= id_ours ? ST_OPW : ST_IDLE;
      end else begin
         case (state)
            ST_OPW: if (xfer_wr) begin
               op_q    <= dec_now.op;
               dbl_q   <= dec_now.dbl;
               ill_q   <= dec_now.illegal;
               mkres_q <= dec_now.makes_res;
               need_q  <= dec_now.two_src ? (wpo_now << 1) : wpo_now;
               state   <= dec_now.illegal ? ST_DONE : ST_OPND;
            end
            ST_OPND: if (last_w) state <= ST_EXEC;
            ST_EXEC: if (ex_fin) state <= ST_DONE;
            ST_DONE: state <= ST_STAT;
            ST_STAT: if (stat_rd) begin
               ridx  <= '0;
               state <= (mkres_q && !ill_q) ? ST_RES : ST_IDLE;
            end
            ST_RES: if (xfer_rd) begin
               if (ridx == wpo_q - IW'(1))
                  state <= ST_IDLE;
               else
                  ridx <= ridx + IW'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      stat_w             = '0;
      stat_w[2:0]        = ill_q ? TRAP_ILL : TRAP_NONE;
      stat_w[STAT_Z_BIT] = !ill_q && (op_q == OP_CMP) && ex_z;
      stat_w[STAT_N_BIT] = !ill_q && (op_q == OP_CMP) && ex_n;
   end

   always_comb begin
      case (state)
         ST_STAT: bus_dout = stat_w;
         ST_RES:  bus_dout = res_all[int'(ridx)*DW +: DW];
         default: bus_dout = '0;
      endcase
   end

   assign bus_dout_en = (state == ST_STAT) || (state == ST_RES);
   assign done_stb_oe = (state == ST_DONE);
   assign done_stb_n  = (state != ST_DONE);

endmodule

// File: rtl/fps_seq_chk.sv
module fps_seq_chk
   import fps_pkg::*;
#(
   parameter int             DW      = 16,
   parameter int             IDW     = 8,
   parameter logic [IDW-1:0] ID_CODE = 8'hA6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_stb,
   input logic          bus_rd,
   input logic [1:0]    bus_phase,
   input logic [DW-1:0] bus_din,
   input logic [DW-1:0] bus_dout,
   input logic          bus_dout_en,
   input logic          done_stb_n,
   input logic          done_stb_oe,
   input seq_st_t       state
);

   logic id_w;
   assign id_w = bus_stb && !bus_rd && (bus_phase == 2'b11);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (done_stb_n && !done_stb_oe && !bus_dout_en));

   p_foreign_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (id_w && bus_din[IDW-1:0] != ID_CODE) |=> (state == ST_IDLE));

   p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_stb_n |=> done_stb_n);

   p_exec_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC) |-> done_stb_n);

   p_trap_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OPW && bus_stb && !bus_rd && bus_phase == 2'b01 && bus_din[2:1] == 2'b11)
      |=> !done_stb_n);

   p_status_layout_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STAT) |-> (bus_dout[DW-1:6] == '0 && bus_dout[3] == 1'b0 && bus_dout_en));

   p_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_stb_n |=> (state == ST_STAT));

   p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (id_w && bus_din[IDW-1:0] == ID_CODE) |=> (state == ST_OPW && done_stb_n));

   p_line_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb_oe != done_stb_n);

endmodule

bind fps_seq fps_seq_chk #(.DW(DW), .IDW(IDW), .ID_CODE(ID_CODE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_stb     (bus_stb),
   .bus_rd      (bus_rd),
   .bus_phase   (bus_phase),
   .bus_din     (bus_din),
   .bus_dout    (bus_dout),
   .bus_dout_en (bus_dout_en),
   .done_stb_n  (done_stb_n),
   .done_stb_oe (done_stb_oe),
   .state       (state)
);

// File: tb/tb_fps_seq.sv
`timescale 1ns/1ps
module tb_fps_seq;

   localparam int         LAT = 4;
   localparam logic [7:0] IDC = 8'hA6;
   localparam logic [1:0] P_NONE = 2'b00, P_XFER = 2'b01, P_STAT = 2'b10, P_ID = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_stb = 1'b0;
   logic        bus_rd = 1'b0;
   logic [1:0]  bus_phase = 2'b00;
   logic [15:0] bus_din = 16'h0;
   logic [15:0] bus_dout;
   logic        bus_dout_en, done_stb_n, done_stb_oe;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   fps_seq dut (
      .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_rd(bus_rd),
      .bus_phase(bus_phase), .bus_din(bus_din), .bus_dout(bus_dout),
      .bus_dout_en(bus_dout_en), .done_stb_n(done_stb_n), .done_stb_oe(done_stb_oe)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   int          m_st = 0;
   int          m_op, m_wpo, m_need, m_got, m_cnt;
   logic [15:0] ma [4];
   logic [15:0] mb [4];
   logic [15:0] mrq [$];
   logic [15:0] mstat = 16'h0;

   task model_exec();
      longint va, vb;
      logic [15:0] w;
      if (m_wpo == 2) begin
         va = longint'($signed({ma[1], ma[0]}));
         vb = longint'($signed({mb[1], mb[0]}));
      end else begin
         va = $signed({ma[3], ma[2], ma[1], ma[0]});
         vb = $signed({mb[3], mb[2], mb[1], mb[0]});
      end
      mstat = 16'h0;
      mrq.delete();
      if (m_op == 2) begin
         mstat[4] = (va == vb);
         mstat[5] = (va < vb);
      end else begin
         for (int i = 0; i < m_wpo; i++) begin
            case (m_op)
               1: w = ma[i] ^ mb[i];
               5: w = ma[i] & mb[i];
               3: w = (i == m_wpo-1) ? (ma[i] ^ 16'h8000) : ma[i];
               4: w = (i == m_wpo-1) ? (ma[i] & 16'h7FFF) : ma[i];
               default: w = ma[i];
            endcase
            mrq.push_back(w);
         end
      end
   endtask

   task model_step();
      logic ws, rs;
      ws = bus_stb && !bus_rd;
      rs = bus_stb && bus_rd;
      if (ws && bus_phase == P_ID) begin
         m_st = (bus_din[7:0] == IDC) ? 1 : 0;
         mrq.delete();
         return;
      end
      case (m_st)
         1: if (ws && bus_phase == P_XFER) begin
            m_op  = int'(bus_din[2:0]);
            m_wpo = bus_din[3] ? 4 : 2;
            if (m_op >= 6) begin
               mstat = 16'h0004;
               mrq.delete();
               m_st = 4;
            end else begin
               m_need = ((m_op == 1 || m_op == 2 || m_op == 5) ? 2 : 1) * m_wpo;
               m_got = 0;
               m_st = 2;
            end
         end
         2: if (ws && bus_phase == P_XFER) begin
            if (m_got < m_wpo) ma[m_got] = bus_din;
            else mb[m_got - m_wpo] = bus_din;
            m_got++;
            if (m_got == m_need) begin
               m_st = 3;
               m_cnt = LAT;
            end
         end
         3: begin
            m_cnt--;
            if (m_cnt == 0) begin
               model_exec();
               m_st = 4;
            end
         end
         4: m_st = 5;
         5: if (rs && bus_phase == P_STAT) m_st = (mrq.size() > 0) ? 6 : 0;
         6: if (rs && bus_phase == P_XFER) begin
            void'(mrq.pop_front());
            if (mrq.size() == 0) m_st = 0;
         end
         default: m_st = 0;
      endcase
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0;
         mrq.delete();
      end else begin
         model_step();
      end
   end

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R6", done_stb_n, (m_st == 4) ? 1'b0 : 1'b1, "model done_stb_n");
         chk("R12", done_stb_oe, (m_st == 4) ? 1'b1 : 1'b0, "model done_stb_oe");
         chk("R8", bus_dout_en, (m_st == 5 || m_st == 6) ? 1'b1 : 1'b0, "model dout_en");
         if (m_st == 5) chk("R8", bus_dout, mstat, "model status word");
         if (m_st == 6 && mrq.size() > 0) chk("R10", bus_dout, mrq[0], "model result word");
      end
   end

   // ---------------- host-side helpers ----------------
   task automatic wr(logic [1:0] ph, logic [15:0] d);
      @(negedge clk);
      bus_stb = 1'b1; bus_rd = 1'b0; bus_phase = ph; bus_din = d;
      @(negedge clk);
      bus_stb = 1'b0; bus_phase = P_NONE; bus_din = 16'h0;
   endtask

   task automatic rdw(logic [1:0] ph, output logic [15:0] v);
      @(negedge clk);
      bus_stb = 1'b1; bus_rd = 1'b1; bus_phase = ph;
      v = bus_dout;
      @(negedge clk);
      bus_stb = 1'b0; bus_rd = 1'b0; bus_phase = P_NONE;
   endtask

   task automatic wait_done(output int k);
      k = 0;
      while (done_stb_n === 1'b1 && k < 40) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic send_words(logic [15:0] w [8], int nw);
      for (int i = 0; i < nw; i++) wr(P_XFER, w[i]);
   endtask

   task automatic read_results(string req, logic [15:0] exp [4], int nr);
      logic [15:0] v;
      for (int i = 0; i < nr; i++) begin
         rdw(P_XFER, v);
         chk(req, v, exp[i], $sformatf("result word %0d", i));
      end
      chk(req, bus_dout_en, 1'b0, "idle after results");
   endtask

   task automatic run_op(string req, logic [15:0] opw, logic [15:0] w [8], int nw,
                         logic [15:0] exp_stat, logic [15:0] exp [4], int nr);
      int k;
      logic [15:0] v;
      wr(P_ID, {8'h00, IDC});
      wr(P_XFER, opw);
      send_words(w, nw);
      wait_done(k);
      chk("R6", k, LAT, $sformatf("%s done delay", req));
      rdw(P_STAT, v);
      chk(req, v, exp_stat, "status word");
      read_results(req, exp, nr);
   endtask

   initial begin
      int k;
      logic [15:0] v;
      logic [15:0] w [8];
      logic [15:0] e [4];
      logic        seen;

      // R1: quiet during and right after reset
      repeat (3) @(negedge clk);
      chk("R1", done_stb_n, 1'b1, "reset done_stb_n");
      chk("R1", done_stb_oe, 1'b0, "reset done_stb_oe");
      chk("R1", bus_dout_en, 1'b0, "reset dout_en");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R12", done_stb_oe, 1'b0, "released line after reset");

      // R3 R4 R10: single move
      w = '{16'h5678, 16'h1234, 0, 0, 0, 0, 0, 0};
      e = '{16'h5678, 16'h1234, 0, 0};
      run_op("R10", 16'h0000, w, 2, 16'h0000, e, 2);

      // R3 R4: double xor, two operands of four words
      w = '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h000F, 16'h00F0, 16'h0F00, 16'hF000};
      e = '{16'h111E, 16'h22D2, 16'h3C33, 16'hB444};
      run_op("R4", 16'h0009, w, 8, 16'h0000, e, 4);

      // R9: compare equal, single
      w = '{16'h0001, 16'h8000, 16'h0001, 16'h8000, 0, 0, 0, 0};
      run_op("R9", 16'h0002, w, 4, 16'h0010, e, 0);

      // R9: compare first below second (negative vs positive)
      w = '{16'h0000, 16'h8000, 16'h0005, 16'h0000, 0, 0, 0, 0};
      run_op("R9", 16'h0002, w, 4, 16'h0020, e, 0);

      // R9: compare double, first above second
      w = '{16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
      run_op("R9", 16'h000A, w, 8, 16'h0000, e, 0);

      // R10: negate double flips top bit of top word
      w = '{16'hAAAA, 16'hBBBB, 16'hCCCC, 16'h1234, 0, 0, 0, 0};
      e = '{16'hAAAA, 16'hBBBB, 16'hCCCC, 16'h9234};
      run_op("R10", 16'h000B, w, 4, 16'h0000, e, 4);

      // R10: absolute single clears top bit
      w = '{16'h00FF, 16'hF0F0, 0, 0, 0, 0, 0, 0};
      e = '{16'h00FF, 16'h70F0, 0, 0};
      run_op("R10", 16'h0004, w, 2, 16'h0000, e, 2);

      // R10: and single
      w = '{16'hFF00, 16'h0FF0, 16'h0F0F, 16'hFFFF, 0, 0, 0, 0};
      e = '{16'h0F00, 16'h0FF0, 0, 0};
      run_op("R10", 16'h0005, w, 4, 16'h0000, e, 2);

      // R7: illegal forms 6 and 7 trap at once
      wr(P_ID, {8'h00, IDC});
      wr(P_XFER, 16'h0006);
      wait_done(k);
      chk("R7", k, 0, "trap pulse delay op6");
      rdw(P_STAT, v);
      chk("R7", v, 16'h0004, "trap status op6");
      chk("R7", bus_dout_en, 1'b0, "no result words op6");
      wr(P_ID, {8'h00, IDC});
      wr(P_XFER, 16'h000F);
      wait_done(k);
      chk("R7", k, 0, "trap pulse delay op7");
      rdw(P_STAT, v);
      chk("R7", v, 16'h0004, "trap status op7");

      // R2: foreign identification byte, following writes ignored
      wr(P_ID, 16'h0055);
      wr(P_XFER, 16'h0000);
      wr(P_XFER, 16'h1111);
      wr(P_XFER, 16'h2222);
      seen = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (done_stb_n !== 1'b1 || bus_dout_en !== 1'b0) seen = 1'b1;
      end
      chk("R2", seen, 1'b0, "activity after foreign id");

      // R5: mismatched strobes during operand collection
      wr(P_ID, {8'h00, IDC});
      wr(P_XFER, 16'h0000);
      wr(P_XFER, 16'hCAFE);
      rdw(P_XFER, v);
      wr(P_STAT, 16'hDEAD);
      wr(P_NONE, 16'hBEEF);
      wr(P_XFER, 16'h0BAD);
      wait_done(k);
      chk("R5", k, LAT, "done delay with ignored strobes");
      rdw(P_STAT, v);
      chk("R5", v, 16'h0000, "status with ignored strobes");
      e = '{16'hCAFE, 16'h0BAD, 0, 0};
      read_results("R5", e, 2);

      // R11: abort during execution, then restart
      wr(P_ID, {8'h00, IDC});
      wr(P_XFER, 16'h0001);
      w = '{16'h1, 16'h2, 16'h3, 16'h4, 0, 0, 0, 0};
      send_words(w, 4);
      wr(P_ID, {8'h00, IDC});
      seen = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (done_stb_n !== 1'b1) seen = 1'b1;
      end
      chk("R11", seen, 1'b0, "no pulse after abort in execution");
      wr(P_XFER, 16'h0000);
      w = '{16'h7777, 16'h8888, 0, 0, 0, 0, 0, 0};
      send_words(w, 2);
      wait_done(k);
      chk("R11", k, LAT, "restart done delay");
      rdw(P_STAT, v);
      chk("R11", v, 16'h0000, "restart status");
      e = '{16'h7777, 16'h8888, 0, 0};
      read_results("R11", e, 2);

      // R11: abort during operand collection discards partial operands
      wr(P_ID, {8'h00, IDC});
      wr(P_XFER, 16'h0009);
      w = '{16'hAAAA, 16'hBBBB, 16'hCCCC, 0, 0, 0, 0, 0};
      send_words(w, 3);
      w = '{16'h0123, 16'h4567, 0, 0, 0, 0, 0, 0};
      e = '{16'h0123, 16'h4567, 0, 0};
      run_op("R11", 16'h0000, w, 2, 16'h0000, e, 2);

      repeat (4) @(negedge clk);
      chk("R12", done_stb_oe, 1'b0, "line released at end");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 20000);
      bad++;
      total++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule